// File: doc/BRIEF.md
# Receive Timestamp Prefix Inserter

This block sits in a receive byte stream between the MAC and the buffer manager. For each incoming frame it holds the first bytes of the frame and classifies them against a timestamp control word. That word can select PTP carried directly over Ethernet, over IPv4 UDP or over IPv6 UDP, the PTP version, and which event messages count. A frame that matches gets a 16-byte prefix ahead of its MAC header. The prefix holds the arrival time: the seconds and nanoseconds of the live time counter, captured when the first byte of the frame was accepted. While the frame leaves the block, a flag is raised beside it so that the descriptor writer can mark the frame as carrying a hardware timestamp.

The block buffers at most `HDR_DEPTH` header bytes. It decides one cycle after the last of them arrives or after the frame ends, whichever comes first. It then emits the prefix, if one is due, followed by the buffered bytes, and passes the rest of the frame straight through. The input is held off while the prefix and the buffered bytes are sent. The control word is sampled at the moment of the decision.

Top module: `ptp_rx_ts_prepend`

## Requirements
- R1: A stamped frame leaves as 16 prefix bytes followed by the unchanged frame. Prefix bytes 0 to 7 are zero, bytes 8 to 11 are the seconds value most significant byte first, and bytes 12 to 15 are the nanoseconds value most significant byte first.
- R2: The seconds and nanoseconds in the prefix are the `sec_i` and `nsec_i` values present in the cycle in which the frame's first byte is accepted. Later changes to those inputs have no effect on the prefix.
- R3: `ts_flag_o` is high on every output beat of a stamped frame and low on every beat of an unstamped frame. An unstamped frame leaves byte for byte unchanged, with no prefix.
- R4: The control word bits are: bit 0 stamp every frame, bit 1 IPv4 UDP, bit 2 IPv6 UDP, bit 3 Ethernet, bit 4 version 2, bit 5 master role, bit 6 all event types. When bits 3:0 are all zero, no frame is stamped.
- R5: With bit 0 set, every frame is stamped whatever its content or length, including frames shorter than any transport header.
- R6: Transport match, counting byte offsets from the first frame byte, with the PTP message start written "msg". For Ethernet, bytes 12 and 13 are 0x88F7 and msg is 14. For IPv4, bytes 12 and 13 are 0x0800, byte 14 is 0x45, byte 23 is 17, the UDP destination port in bytes 36 and 37 is 319, and msg is 42. For IPv6, bytes 12 and 13 are 0x86DD, byte 20 is 17, the port in bytes 56 and 57 is 319, and msg is 62. Each transport counts only when its enable bit is set.
- R7: The low nibble of byte msg+1 must equal 2 when bit 4 is set, and must equal 1 when it is clear.
- R8: For version 2 only, the message type is the low nibble of byte msg. With bit 6 set, types 0 to 3 pass. Otherwise bit 5 set passes only type 1, and bit 5 clear passes only type 0. Version 1 frames have no type filter.
- R9: `in_ready_o` is low while the prefix and the buffered bytes are sent. Under output back-pressure no byte is lost or duplicated, and an offered output beat stays stable until it is taken.
- R10: `out_sof_o` is set on the first output beat of a frame only (the first prefix byte when stamped). `out_eof_o` is set on the last beat only.
- R11: Input bytes that arrive between frames without `in_sof_i` are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 7 | Timestamp control word (R4 bit map) |
| sec_i | input | 32 | Live seconds from the time counter |
| nsec_i | input | 32 | Live nanoseconds from the time counter |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted when high with valid |
| in_data_i | input | 8 | Input byte |
| in_sof_i | input | 1 | Input byte is the first of a frame |
| in_eof_i | input | 1 | Input byte is the last of a frame |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream accepts the output byte |
| out_data_o | output | 8 | Output byte |
| out_sof_o | output | 1 | First output byte of a frame |
| out_eof_o | output | 1 | Last output byte of a frame |
| ts_flag_o | output | 1 | Frame carries a timestamp prefix |

## Verification
The assertions check on every cycle the stream rules: an offered beat holds until taken, the input is held off while the prefix starts, no beat follows an end marker in the next cycle, and the flag stays up across a stamped frame. With the transport bits clear, no decision may stamp. The frame-level behaviour can only be shown by the bench's scenarios: the exact prefix bytes, the capture instant of the time, the match rules for each transport, the version and message-type filters, and byte integrity under back-pressure across the end of the buffered header.

// File: rtl/ptp_rx_pkg.sv
package ptp_rx_pkg;
  localparam int CTRL_W      = 7;
  localparam int PREFIX_LEN  = 16;
  localparam int MIN_DEPTH   = 64;

  localparam int C_ALL       = 0;
  localparam int C_IPV4      = 1;
  localparam int C_IPV6      = 2;
  localparam int C_ETH       = 3;
  localparam int C_VER2      = 4;
  localparam int C_MASTER    = 5;
  localparam int C_EVENTS    = 6;

  localparam logic [15:0] ETYPE_PTP  = 16'h88F7;
  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam logic [15:0] ETYPE_IPV6 = 16'h86DD;
  localparam logic [15:0] UDP_EVENT  = 16'd319;
  localparam logic [7:0]  PROTO_UDP  = 8'd17;

  typedef enum logic [2:0] {
    ST_FILL, ST_DECIDE, ST_PREFIX, ST_DRAIN, ST_PASS
  } state_t;
endpackage

// File: rtl/ptp_rx_hdr_buf.sv
module ptp_rx_hdr_buf #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [7:0]           wr_data_i,
  input  logic [IDX_W-1:0]     rd_idx_i,
  output logic [7:0]           rd_data_o,
  output logic [DEPTH*8-1:0]   flat_o
);
  logic [7:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g)) mem_q[g] <= wr_data_i;
    end
    assign flat_o[8*g +: 8] = mem_q[g];
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/ptp_rx_classifier.sv
module ptp_rx_classifier
  import ptp_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH*8-1:0] hdr_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [CTRL_W-1:0]  ctrl_i,
  output logic               stamp_o
);
  localparam int ETH_MSG = 14;
  localparam int V4_MSG  = 42;
  localparam int V6_MSG  = 62;

  function automatic logic [7:0] hb(input int k);
    return hdr_i[8*k +: 8];
  endfunction

  logic [15:0] etype;
  logic        eth_hit, v4_hit, v6_hit, any_hit;
  logic [3:0]  msg_type, msg_ver;
  logic        ver_ok, type_ok;

  always_comb begin
    etype   = {hb(12), hb(13)};
    eth_hit = ctrl_i[C_ETH] && len_i >= LEN_W'(ETH_MSG + 2) && etype == ETYPE_PTP;
    v4_hit  = ctrl_i[C_IPV4] && len_i >= LEN_W'(V4_MSG + 2) && etype == ETYPE_IPV4
              && hb(14) == 8'h45 && hb(23) == PROTO_UDP
              && {hb(36), hb(37)} == UDP_EVENT;
    v6_hit  = ctrl_i[C_IPV6] && len_i >= LEN_W'(V6_MSG + 2) && etype == ETYPE_IPV6
              && hb(20) == PROTO_UDP && {hb(56), hb(57)} == UDP_EVENT;
    any_hit = eth_hit || v4_hit || v6_hit;

    if (eth_hit) begin
      msg_type = hb(ETH_MSG)[3:0];
      msg_ver  = hb(ETH_MSG + 1)[3:0];
    end else if (v4_hit) begin
      msg_type = hb(V4_MSG)[3:0];
      msg_ver  = hb(V4_MSG + 1)[3:0];
    end else begin
      msg_type = hb(V6_MSG)[3:0];
      msg_ver  = hb(V6_MSG + 1)[3:0];
    end

    ver_ok = ctrl_i[C_VER2] ? (msg_ver == 4'd2) : (msg_ver == 4'd1);
    if (!ctrl_i[C_VER2])      type_ok = 1'b1;
    else if (ctrl_i[C_EVENTS]) type_ok = (msg_type <= 4'd3);
    else if (ctrl_i[C_MASTER]) type_ok = (msg_type == 4'd1);
    else                       type_ok = (msg_type == 4'd0);

    stamp_o = ctrl_i[C_ALL] || (any_hit && ver_ok && type_ok);
  end
endmodule

// File: rtl/ptp_rx_prefix.sv
module ptp_rx_prefix
  import ptp_rx_pkg::*;
(
  input  logic [31:0] sec_i,
  input  logic [31:0] nsec_i,
  input  logic [3:0]  idx_i,
  output logic [7:0]  byte_o
);
  logic [PREFIX_LEN*8-1:0] pv;
  int sh;

  always_comb begin
    pv     = {64'h0, sec_i, nsec_i};
    sh     = 8 * (PREFIX_LEN - 1 - int'(idx_i));
    byte_o = pv[sh +: 8];
  end
endmodule

// File: rtl/ptp_rx_ts_prepend.sv
module ptp_rx_ts_prepend
  import ptp_rx_pkg::*;
#(
  parameter int HDR_DEPTH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [31:0]       sec_i,
  input  logic [31:0]       nsec_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [7:0]        in_data_i,
  input  logic              in_sof_i,
  input  logic              in_eof_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [7:0]        out_data_o,
  output logic              out_sof_o,
  output logic              out_eof_o,
  output logic              ts_flag_o
);
  localparam int CNT_W = $clog2(HDR_DEPTH + 1);
  localparam int IDX_W = $clog2(HDR_DEPTH);

  if (HDR_DEPTH < MIN_DEPTH) begin : g_bad_depth
    $error("HDR_DEPTH must cover the deepest transport header");
  end

  state_t            st_q;
  logic [CNT_W-1:0]  cnt_q, idx_q;
  logic              eof_q, stamp_q;
  logic [31:0]       sec_q, nsec_q;
  logic              fill_wr, cls_stamp;
  logic [7:0]        buf_byte, pre_byte;
  logic [HDR_DEPTH*8-1:0] hdr_flat;
  logic              drain_last;

  assign fill_wr    = st_q == ST_FILL && in_valid_i && (cnt_q != '0 || in_sof_i);
  assign drain_last = idx_q == cnt_q - 1'b1;

  ptp_rx_hdr_buf #(.DEPTH(HDR_DEPTH)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (fill_wr),
    .wr_idx_i (cnt_q[IDX_W-1:0]),
    .wr_data_i(in_data_i),
    .rd_idx_i (idx_q[IDX_W-1:0]),
    .rd_data_o(buf_byte),
    .flat_o   (hdr_flat)
  );

  ptp_rx_classifier #(.DEPTH(HDR_DEPTH)) u_cls (
    .hdr_i  (hdr_flat),
    .len_i  (cnt_q),
    .ctrl_i (ctrl_i),
    .stamp_o(cls_stamp)
  );

  ptp_rx_prefix u_pre (
    .sec_i (sec_q),
    .nsec_i(nsec_q),
    .idx_i (idx_q[3:0]),
    .byte_o(pre_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_FILL;
      cnt_q   <= '0;
      idx_q   <= '0;
      eof_q   <= 1'b0;
      stamp_q <= 1'b0;
      sec_q   <= '0;
      nsec_q  <= '0;
    end else begin
      unique case (st_q)
        ST_FILL: if (fill_wr) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == '0) begin
            sec_q  <= sec_i;
            nsec_q <= nsec_i;
          end
          if (in_eof_i || cnt_q == CNT_W'(HDR_DEPTH - 1)) begin
            st_q  <= ST_DECIDE;
            eof_q <= in_eof_i;
          end
        end
        ST_DECIDE: begin
          stamp_q <= cls_stamp;
          idx_q   <= '0;
          st_q    <= cls_stamp ? ST_PREFIX : ST_DRAIN;
        end
        ST_PREFIX: if (out_ready_i) begin
          if (idx_q == CNT_W'(PREFIX_LEN - 1)) begin
            idx_q <= '0;
            st_q  <= ST_DRAIN;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_DRAIN: if (out_ready_i) begin
          if (drain_last) begin
            idx_q <= '0;
            cnt_q <= '0;
            st_q  <= eof_q ? ST_FILL : ST_PASS;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_PASS: if (in_valid_i && out_ready_i && in_eof_i) st_q <= ST_FILL;
        default: st_q <= ST_FILL;
      endcase
    end
  end

  always_comb begin
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    out_data_o  = 8'h00;
    out_sof_o   = 1'b0;
    out_eof_o   = 1'b0;
    ts_flag_o   = 1'b0;
    unique case (st_q)
      ST_FILL: in_ready_o = 1'b1;
      ST_PREFIX: begin
        out_valid_o = 1'b1;
        out_data_o  = pre_byte;
        out_sof_o   = idx_q == '0;
        ts_flag_o   = stamp_q;
      end
      ST_DRAIN: begin
        out_valid_o = 1'b1;
        out_data_o  = buf_byte;
        out_sof_o   = idx_q == '0 && !stamp_q;
        out_eof_o   = eof_q && drain_last;
        ts_flag_o   = stamp_q;
      end
      ST_PASS: begin
        in_ready_o  = out_ready_i;
        out_valid_o = in_valid_i;
        out_data_o  = in_data_i;
        out_eof_o   = in_eof_i;
        ts_flag_o   = stamp_q;
      end
      default: ;
    endcase
  end

  // R9
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)
      && $stable(out_sof_o) && $stable(out_eof_o)))
    else $error("output beat changed before it was taken");

  // R1
  prefix_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_sof_o && ts_flag_o) |-> (!in_ready_o && out_data_o == 8'h00))
    else $error("prefix start with input open or nonzero byte");

  // R10
  eof_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_eof_o) |=> !out_valid_o)
    else $error("beat right after end of frame");

  // R3
  flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !out_eof_o && ts_flag_o) |=> (!out_valid_o || ts_flag_o))
    else $error("stamp flag dropped inside a frame");

  // R4
  no_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DECIDE && ctrl_i[3:0] == 4'd0) |=> !ts_flag_o)
    else $error("stamped with all enables clear");
endmodule

// File: tb/ptp_rx_ts_prepend_bench.sv
`timescale 1ns/100ps
module ptp_rx_ts_prepend_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  ctrl_i = '0;
  logic [31:0] sec_i, nsec_i;
  logic        in_valid_i = 1'b0, in_sof_i = 1'b0, in_eof_i = 1'b0;
  logic [7:0]  in_data_i = '0;
  logic        in_ready_o, out_valid_o, out_sof_o, out_eof_o, ts_flag_o;
  logic        out_ready_i = 1'b1;
  logic [7:0]  out_data_o;

  always #2.5 clk_i = ~clk_i;

  ptp_rx_ts_prepend u_ptp_rx_ts_prepend (.*);

  int n_chk = 0, n_fail = 0;
  logic [31:0] tcnt = '0;
  always @(negedge clk_i) tcnt <= tcnt + 1;
  assign sec_i  = 32'h5EC0_0000 + tcnt;
  assign nsec_i = 32'h0100_0000 + tcnt * 7;

  logic bp_en = 1'b0;
  logic [7:0] lfsr = 8'hA7;
  always @(negedge clk_i) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready_i <= bp_en ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  logic [7:0] frm [0:127];
  int frm_len;
  logic [7:0] rx_d [0:255];
  logic rx_s [0:255], rx_e [0:255], rx_f [0:255];
  int rx_n = 0;
  logic [31:0] exp_sec, exp_nsec;

  always @(negedge clk_i) begin
    #1;
    if (rst_ni && out_valid_o && out_ready_i && rx_n < 256) begin
      rx_d[rx_n] = out_data_o; rx_s[rx_n] = out_sof_o;
      rx_e[rx_n] = out_eof_o;  rx_f[rx_n] = ts_flag_o;
      rx_n++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic void fill_base(input int len);
    for (int i = 0; i < len; i++) frm[i] = 8'(i * 13 + 7);
    frm[12] = 8'h08; frm[13] = 8'h06;
    frm_len = len;
  endfunction

  function automatic void build_eth(input int ver, input int mt, input int len);
    fill_base(len);
    frm[12] = 8'h88; frm[13] = 8'hF7; frm[14] = 8'(mt); frm[15] = 8'(ver);
  endfunction

  function automatic void build_v4(input int ver, input int mt, input int len);
    fill_base(len);
    frm[12] = 8'h08; frm[13] = 8'h00; frm[14] = 8'h45; frm[23] = 8'd17;
    frm[36] = 8'h01; frm[37] = 8'h3F; frm[42] = 8'(mt); frm[43] = 8'(ver);
  endfunction

  function automatic void build_v6(input int ver, input int mt, input int len);
    fill_base(len);
    frm[12] = 8'h86; frm[13] = 8'hDD; frm[20] = 8'd17;
    frm[56] = 8'h01; frm[57] = 8'h3F; frm[62] = 8'(mt); frm[63] = 8'(ver);
  endfunction

  task automatic drive_frame();
    for (int i = 0; i < frm_len; i++) begin
      @(negedge clk_i);
      in_valid_i = 1'b1; in_data_i = frm[i];
      in_sof_i = (i == 0); in_eof_i = (i == frm_len - 1);
      #1;
      while (!in_ready_o) begin @(negedge clk_i); #1; end
      if (i == 0) begin exp_sec = sec_i; exp_nsec = nsec_i; end
    end
    @(negedge clk_i);
    in_valid_i = 1'b0; in_sof_i = 1'b0; in_eof_i = 1'b0;
  endtask

  task automatic run_case(input bit stamp, input string req);
    int n_exp, bad, t;
    logic [7:0] e;
    bit sf_ok, fl_ok;
    rx_n = 0;
    drive_frame();
    t = 0;
    while ((rx_n == 0 || !rx_e[rx_n-1]) && t < 2000) begin @(negedge clk_i); t++; end
    repeat (3) @(negedge clk_i);
    n_exp = frm_len + (stamp ? 16 : 0);
    check(rx_n == n_exp, req, "beat count", rx_n, n_exp);
    bad = -1;
    for (int j = 0; j < n_exp && j < rx_n; j++) begin
      if (stamp && j < 8) e = 8'h00;
      else if (stamp && j < 12) e = exp_sec[8*(11-j) +: 8];
      else if (stamp && j < 16) e = exp_nsec[8*(15-j) +: 8];
      else e = frm[j - (stamp ? 16 : 0)];
      if (bad < 0 && rx_d[j] !== e) bad = j;
    end
    check(bad < 0, stamp ? "R1" : "R3", "byte content at first mismatch",
          bad < 0 ? 0 : rx_d[bad], bad);
    sf_ok = 1; fl_ok = 1;
    for (int j = 0; j < rx_n; j++) begin
      if (rx_s[j] !== (j == 0) || rx_e[j] !== (j == rx_n - 1)) sf_ok = 0;
      if (rx_f[j] !== stamp) fl_ok = 0;
    end
    check(sf_ok, "R10", "frame markers", sf_ok, 1);
    check(fl_ok, {"R3 ", req}, "stamp flag", rx_n > 0 ? rx_f[0] : 0, stamp);
  endtask

  task automatic t_reset();
    @(negedge clk_i); #1;
    check(in_ready_o == 1'b1, "R9", "ready after reset", in_ready_o, 1);
    check(out_valid_o == 1'b0 && ts_flag_o == 1'b0, "R3", "idle outputs", out_valid_o, 0);
  endtask

  task automatic t_no_enable();
    ctrl_i = 7'h00;
    build_eth(2, 0, 60); run_case(0, "R4");
    build_v4(2, 0, 70); run_case(0, "R4");
  endtask

  task automatic t_eth();
    ctrl_i = 7'b0011000;
    build_eth(2, 0, 60); run_case(1, "R6");
    check(rx_n > 12 && {rx_d[8], rx_d[9], rx_d[10], rx_d[11]} == exp_sec,
          "R2", "captured seconds", {rx_d[8], rx_d[9], rx_d[10], rx_d[11]}, exp_sec);
  endtask

  task automatic t_ipv4_ipv6();
    ctrl_i = 7'b0010010;
    build_v4(2, 0, 70); run_case(1, "R6");
    build_v6(2, 0, 80); run_case(0, "R6");
    build_eth(2, 0, 60); run_case(0, "R6");
    ctrl_i = 7'b0010100;
    build_v6(2, 0, 80); run_case(1, "R6");
    build_v4(2, 0, 70); run_case(0, "R6");
  endtask

  task automatic t_version();
    ctrl_i = 7'b0001000;
    build_eth(2, 0, 60); run_case(0, "R7");
    build_eth(1, 9, 60); run_case(1, "R7");
    ctrl_i = 7'b0011000;
    build_eth(1, 0, 60); run_case(0, "R7");
  endtask

  task automatic t_msg_type();
    ctrl_i = 7'b0011000;
    build_eth(2, 1, 60); run_case(0, "R8");
    ctrl_i = 7'b0111000;
    build_eth(2, 1, 60); run_case(1, "R8");
    build_eth(2, 0, 60); run_case(0, "R8");
    ctrl_i = 7'b1011000;
    build_eth(2, 3, 60); run_case(1, "R8");
    build_eth(2, 8, 60); run_case(0, "R8");
  endtask

  task automatic t_all();
    ctrl_i = 7'b0000001;
    fill_base(10); run_case(1, "R5");
    fill_base(1);  run_case(1, "R5");
  endtask

  task automatic t_backpressure();
    ctrl_i = 7'b0000001;
    bp_en = 1'b1;
    fill_base(100); run_case(1, "R9");
    ctrl_i = 7'b0000000;
    fill_base(90); run_case(0, "R9");
    bp_en = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic t_junk();
    ctrl_i = 7'b0000001;
    @(negedge clk_i);
    in_valid_i = 1'b1; in_data_i = 8'hEE; in_sof_i = 1'b0; in_eof_i = 1'b0;
    repeat (3) @(negedge clk_i);
    in_valid_i = 1'b0;
    fill_base(20); run_case(1, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_no_enable();
    t_eth();
    t_ipv4_ipv6();
    t_version();
    t_msg_type();
    t_all();
    t_backpressure();
    t_junk();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule